// File: doc/BRIEF.md
# Packed Audio Sample FIFO Channel

This block is one audio channel between a register bus and a streaming audio client. The bus writes 32-bit words into a transmit queue; words leave on the client side as samples over a valid/ready handshake. Samples arriving from the client are gathered into 32-bit words in a receive queue, and the bus reads them back. Either direction can carry one full-width sample per word, two 16-bit samples, or four 8-bit samples, so narrow audio does not waste bus bandwidth.

A control word enables each direction, selects packing per direction, sets two 8-bit thresholds and can turn on an internal loopback. A status word reports free space in both queues, two threshold trigger flags for a DMA engine to poll, and a sticky flag for reads of an empty receive queue. A clear register empties either queue on its own. Live full/empty flags go out as separate pins.

Register word addresses: 0 control, 1 clear (write only), 2 status, 3 transmit data (write), 4 receive data (read). Reads of other addresses return zero.

Top module: `audio_dma_fifo`

## Requirements
- R1: After reset both queues are empty, status reads 0x1010_0003 (16 free entries each, both triggers set with thresholds at zero), `tx_valid_o` is low and `tx_cli_empty`, `tx_bus_empty`, `rx_bus_empty` are high.
- R2: Control holds TX enable in bit 31, RX enable in bit 30, loopback in bit 29, TX threshold in bits 23:16, RX threshold in bits 15:8, TX pack enable in bit 6, TX pack mode in bits 5:4, RX pack enable in bit 2 and RX pack mode in bits 1:0; all other bits read back as zero.
- R3: Unpacked, each transmit word leaves as one 32-bit sample in write order, and only while TX enable is set.
- R4: With TX packing on, mode 3 sends each word as two samples (bits 15:0 first, then 31:16) and mode 2 as four samples (bits 7:0 first, up to 31:24), each zero-extended on `tx_data_o`; any other mode sends whole words.
- R5: While RX enable is set, the receive side accepts one sample per handshake; unpacked each sample is one word, mode 3 gathers the low 16 bits of two samples and mode 2 the low 8 bits of four, the earliest in the lowest lane, and a word becomes readable only once complete.
- R6: Status bits 31:24 give free transmit entries and bits 23:16 free receive entries.
- R7: Status bit 1 is set while transmit free entries are at or above the TX threshold; status bit 0 is set while receive occupied entries are at or above the RX threshold.
- R8: A bus write to a full transmit queue is dropped; the queued words are unchanged.
- R9: A read of an empty receive queue returns zero and sets status bit 2, which stays set until an RX soft reset.
- R10: Writing the clear register with bit 31 empties the transmit queue and its unpacking stage; bit 30 empties the receive queue, its packing stage and status bit 2; neither touches the other direction.
- R11: With loopback set, transmit samples feed the receive side directly; `tx_valid_o` and `rx_ready_o` stay low and `rx_valid_i`/`rx_data_i`/`tx_ready_i` have no effect.
- R12: `tx_bus_full`/`tx_bus_empty` and `rx_bus_full`/`rx_bus_empty` follow the queue levels; `tx_cli_empty` is high while no transmit sample is on offer, and `rx_cli_full` is high while the receive side refuses a sample.
- R13: Once `tx_valid_o` is high it stays high with stable `tx_data_o` until `tx_ready_i` accepts it, as long as no register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of `reg_rd` |
| tx_valid_o | output | 1 | Transmit sample on offer |
| tx_ready_i | input | 1 | Client takes the transmit sample |
| tx_data_o | output | 32 | Transmit sample |
| rx_valid_i | input | 1 | Client offers a receive sample |
| rx_ready_o | output | 1 | Receive sample accepted |
| rx_data_i | input | 32 | Receive sample |
| tx_bus_full | output | 1 | Transmit queue full |
| tx_bus_empty | output | 1 | Transmit queue empty |
| tx_cli_empty | output | 1 | No transmit sample on offer |
| rx_bus_full | output | 1 | Receive queue full |
| rx_bus_empty | output | 1 | Receive queue empty |
| rx_cli_full | output | 1 | Receive side refuses samples |

## Verification
The bench aims at lane order in both packing modes, since a swapped lane or a packer that fails to clear its accumulator would return scrambled or OR-merged words. It fills the transmit queue past capacity and reads the receive queue while empty, where a design that wraps its pointer would overwrite the oldest word and one without the sticky flag would lose the error. Threshold edges are probed one entry either side, catching an off-by-one compare, and loopback is run with live garbage on the external pins so any leak from them shows up as an extra or wrong receive word.

// File: rtl/audfifo_pkg.sv
// Shared constants and types for the packed audio FIFO channel.
package audfifo_pkg;

    localparam int WORD_W = 32;

    // Register word addresses
    typedef enum logic [2:0] {
        RA_CTRL   = 3'd0,
        RA_CLEAR  = 3'd1,
        RA_STATUS = 3'd2,
        RA_TXDATA = 3'd3,
        RA_RXDATA = 3'd4
    } reg_addr_e;

    // Lane layout held by a packing stage
    typedef enum logic [1:0] {
        LAY_WORD = 2'd0,
        LAY_HALF = 2'd1,
        LAY_BYTE = 2'd2
    } lane_lay_e;

    // Control bit positions
    localparam int CB_TX_EN    = 31;
    localparam int CB_RX_EN    = 30;
    localparam int CB_LOOP     = 29;
    localparam int CB_TX_THR   = 16;
    localparam int CB_RX_THR   = 8;
    localparam int CB_TX_PKEN  = 6;
    localparam int CB_TX_PKMD  = 4;
    localparam int CB_RX_PKEN  = 2;
    localparam int CB_RX_PKMD  = 0;
    localparam logic [31:0] CTRL_MASK = 32'hE0FF_FF77;

    // Clear register bit positions
    localparam int CLB_TX = 31;
    localparam int CLB_RX = 30;

    // Decode pack enable and mode into a lane layout
    function automatic lane_lay_e lay_of(input logic en, input logic [1:0] mode);
        if (en && mode == 2'd3) return LAY_HALF;
        if (en && mode == 2'd2) return LAY_BYTE;
        return LAY_WORD;
    endfunction

    // Index of the last lane for a layout
    function automatic logic [1:0] last_of(input lane_lay_e lay);
        case (lay)
            LAY_HALF: return 2'd1;
            LAY_BYTE: return 2'd3;
            default:  return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/audfifo_queue.sv
// Synchronous first-in first-out queue.
// Assumes: push when full and pop when empty are ignored; clr empties it.
module audfifo_queue #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rptr];

    // Storage write
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    // Pointer and level upkeep
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/audfifo_unpack.sv
// Transmit unpacker: takes a word from the queue and offers its lanes one
// per handshake, lowest lane first. Assumes the layout is fixed per word,
// sampled when the word is loaded.
module audfifo_unpack
    import audfifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  lane_lay_e         lay,
    input  logic              q_empty,
    input  logic [WORD_W-1:0] q_rdata,
    output logic              q_pop,
    output logic              s_valid,
    input  logic              s_ready,
    output logic [WORD_W-1:0] s_data
);
    logic              held;
    logic [WORD_W-1:0] word;
    logic [1:0]        lane, last;
    lane_lay_e         hlay;
    logic              fire, done;

    assign s_valid = held && en;
    assign fire    = s_valid && s_ready;
    assign done    = fire && (lane == last);
    assign q_pop   = en && !q_empty && (!held || done);

    // Lane select for the offered sample
    always_comb begin
        case (hlay)
            LAY_HALF: s_data = WORD_W'(word[{lane[0], 4'b0} +: 16]);
            LAY_BYTE: s_data = WORD_W'(word[{lane, 3'b0} +: 8]);
            default:  s_data = word;
        endcase
    end

    // Word hold and lane stepping
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            held <= 1'b0;
            word <= '0;
            lane <= '0;
            last <= '0;
            hlay <= LAY_WORD;
        end else if (q_pop) begin
            held <= 1'b1;
            word <= q_rdata;
            lane <= '0;
            last <= last_of(lay);
            hlay <= lay;
        end else if (done) begin
            held <= 1'b0;
        end else if (fire) begin
            lane <= lane + 1'b1;
        end
    end
endmodule

// File: rtl/audfifo_pack.sv
// Receive packer: gathers narrow samples into a word, lowest lane first,
// and pushes the word when its last lane arrives. Assumes the queue push
// is accepted whenever q_full is low.
module audfifo_pack
    import audfifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  lane_lay_e         lay,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [WORD_W-1:0] s_data,
    input  logic              q_full,
    output logic              q_push,
    output logic [WORD_W-1:0] q_wdata
);
    logic [WORD_W-1:0] acc, placed;
    logic [1:0]        lane;
    logic              at_last, fire;

    assign at_last = (lane >= last_of(lay));
    assign s_ready = en && (!at_last || !q_full);
    assign fire    = s_valid && s_ready;
    assign q_push  = fire && at_last;
    assign q_wdata = acc | placed;

    // Position the incoming sample in its lane
    always_comb begin
        case (lay)
            LAY_HALF: placed = WORD_W'(s_data[15:0]) << {lane[0], 4'b0};
            LAY_BYTE: placed = WORD_W'(s_data[7:0]) << {lane, 3'b0};
            default:  placed = s_data;
        endcase
    end

    // Accumulate lanes and restart after a push
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc  <= '0;
            lane <= '0;
        end else if (q_push) begin
            acc  <= '0;
            lane <= '0;
        end else if (fire) begin
            acc  <= acc | placed;
            lane <= lane + 1'b1;
        end
    end
endmodule

// File: rtl/audio_dma_fifo.sv
// One audio channel: bus-written transmit queue with unpacker, client-fed
// receive queue with packer, control/status/clear registers and loopback.
// Assumes DEPTH <= 255 so free counts fit the 8-bit status fields.
module audio_dma_fifo
    import audfifo_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              tx_valid_o,
    input  logic              tx_ready_i,
    output logic [WORD_W-1:0] tx_data_o,
    input  logic              rx_valid_i,
    output logic              rx_ready_o,
    input  logic [WORD_W-1:0] rx_data_i,
    output logic              tx_bus_full,
    output logic              tx_bus_empty,
    output logic              tx_cli_empty,
    output logic              rx_bus_full,
    output logic              rx_bus_empty,
    output logic              rx_cli_full
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [31:0]       ctrl_q;
    logic              rd_err;
    logic              tx_en, rx_en, loop_en, tx_clr, rx_clr;
    logic [7:0]        tx_thr, rx_thr, tx_free, rx_free, rx_used;
    logic              tx_push, tx_pop, rx_push, rx_pop, rx_empty_rd;
    logic [WORD_W-1:0] tx_q_rdata, rx_q_rdata, rx_q_wdata;
    logic [CW-1:0]     tx_count, rx_count;
    logic              utx_valid, utx_ready, prx_valid, prx_ready;
    logic [WORD_W-1:0] utx_data, prx_data;
    logic [31:0]       status;

    assign tx_en   = ctrl_q[CB_TX_EN];
    assign rx_en   = ctrl_q[CB_RX_EN];
    assign loop_en = ctrl_q[CB_LOOP];
    assign tx_thr  = ctrl_q[CB_TX_THR +: 8];
    assign rx_thr  = ctrl_q[CB_RX_THR +: 8];

    assign tx_clr      = reg_wr && reg_addr == RA_CLEAR && reg_wdata[CLB_TX];
    assign rx_clr      = reg_wr && reg_addr == RA_CLEAR && reg_wdata[CLB_RX];
    assign tx_push     = reg_wr && reg_addr == RA_TXDATA;
    assign rx_empty_rd = reg_rd && reg_addr == RA_RXDATA && rx_bus_empty;
    assign rx_pop      = reg_rd && reg_addr == RA_RXDATA;

    // Control register, unused bits held at zero
    always_ff @(posedge clk) begin
        if (!rst_n)                           ctrl_q <= '0;
        else if (reg_wr && reg_addr == RA_CTRL) ctrl_q <= reg_wdata & CTRL_MASK;
    end

    // Sticky empty-read flag, cleared by RX soft reset
    always_ff @(posedge clk) begin
        if (!rst_n || rx_clr) rd_err <= 1'b0;
        else if (rx_empty_rd) rd_err <= 1'b1;
    end

    audfifo_queue #(.W(WORD_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr),
        .push(tx_push), .wdata(reg_wdata), .pop(tx_pop), .rdata(tx_q_rdata),
        .count(tx_count), .full(tx_bus_full), .empty(tx_bus_empty)
    );

    audfifo_unpack u_unpack (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr), .en(tx_en),
        .lay(lay_of(ctrl_q[CB_TX_PKEN], ctrl_q[CB_TX_PKMD +: 2])),
        .q_empty(tx_bus_empty), .q_rdata(tx_q_rdata), .q_pop(tx_pop),
        .s_valid(utx_valid), .s_ready(utx_ready), .s_data(utx_data)
    );

    audfifo_pack u_pack (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .en(rx_en),
        .lay(lay_of(ctrl_q[CB_RX_PKEN], ctrl_q[CB_RX_PKMD +: 2])),
        .s_valid(prx_valid), .s_ready(prx_ready), .s_data(prx_data),
        .q_full(rx_bus_full), .q_push(rx_push), .q_wdata(rx_q_wdata)
    );

    audfifo_queue #(.W(WORD_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr),
        .push(rx_push), .wdata(rx_q_wdata), .pop(rx_pop), .rdata(rx_q_rdata),
        .count(rx_count), .full(rx_bus_full), .empty(rx_bus_empty)
    );

    // Client-side routing with loopback isolation
    always_comb begin
        tx_data_o  = utx_data;
        tx_valid_o = utx_valid && !loop_en;
        utx_ready  = loop_en ? prx_ready : tx_ready_i;
        prx_valid  = loop_en ? utx_valid : rx_valid_i;
        prx_data   = loop_en ? utx_data  : rx_data_i;
        rx_ready_o = prx_ready && !loop_en;
    end

    assign tx_cli_empty = !utx_valid;
    assign rx_cli_full  = !prx_ready;

    assign tx_free = 8'(DEPTH) - 8'(tx_count);
    assign rx_free = 8'(DEPTH) - 8'(rx_count);
    assign rx_used = 8'(rx_count);
    assign status  = {tx_free, rx_free, 13'b0, rd_err,
                      (tx_free >= tx_thr), (rx_used >= rx_thr)};

    // Register read mux
    always_comb begin
        case (reg_addr)
            RA_CTRL:   reg_rdata = ctrl_q;
            RA_STATUS: reg_rdata = status;
            RA_RXDATA: reg_rdata = rx_bus_empty ? '0 : rx_q_rdata;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/audfifo_chk.sv
// Assertion checker for audio_dma_fifo, bound to every instance.
module audfifo_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic        reg_rd,
    input logic [2:0]  reg_addr,
    input logic [31:0] reg_rdata,
    input logic        tx_valid_o,
    input logic        tx_ready_i,
    input logic [31:0] tx_data_o,
    input logic        rx_ready_o,
    input logic        tx_bus_full,
    input logic        tx_bus_empty,
    input logic        rx_bus_empty,
    input logic        tx_en,
    input logic        loop_en,
    input logic        tx_clr,
    input logic        rx_clr,
    input logic        rd_err
);
    // R8
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd3 && tx_bus_full && !tx_en) |=> tx_bus_full);

    // R9
    empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 3'd4 && rx_bus_empty) |-> (reg_rdata == 32'd0));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 3'd4 && rx_bus_empty && !rx_clr) |=> rd_err);

    // R11
    loop_isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en |-> (!tx_valid_o && !rx_ready_o));

    // R10
    tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_clr |=> (tx_bus_empty && !tx_valid_o));

    // R13
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_ready_i && !reg_wr) |=> (tx_valid_o && $stable(tx_data_o)));
endmodule

bind audio_dma_fifo audfifo_chk i_audfifo_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_rdata(reg_rdata), .tx_valid_o(tx_valid_o),
    .tx_ready_i(tx_ready_i), .tx_data_o(tx_data_o), .rx_ready_o(rx_ready_o),
    .tx_bus_full(tx_bus_full), .tx_bus_empty(tx_bus_empty),
    .rx_bus_empty(rx_bus_empty), .tx_en(tx_en), .loop_en(loop_en),
    .tx_clr(tx_clr), .rx_clr(rx_clr), .rd_err(rd_err)
);

// File: tb/test_audio_dma_fifo.sv
// Directed bench for audio_dma_fifo: one task per scenario.
module test_audio_dma_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        tx_valid_o, tx_ready_i = 1'b0;
    logic [31:0] tx_data_o;
    logic        rx_valid_i = 1'b0, rx_ready_o;
    logic [31:0] rx_data_i = '0;
    logic        tx_bus_full, tx_bus_empty, tx_cli_empty;
    logic        rx_bus_full, rx_bus_empty, rx_cli_full;

    int errs = 0, checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    audio_dma_fifo i_audio_dma_fifo (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .tx_data_o(tx_data_o),
        .rx_valid_i(rx_valid_i), .rx_ready_o(rx_ready_o), .rx_data_i(rx_data_i),
        .tx_bus_full(tx_bus_full), .tx_bus_empty(tx_bus_empty),
        .tx_cli_empty(tx_cli_empty), .rx_bus_full(rx_bus_full),
        .rx_bus_empty(rx_bus_empty), .rx_cli_full(rx_cli_full)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic tx_take(output logic [31:0] d);
        @(negedge clk);
        while (!tx_valid_o) @(negedge clk);
        d = tx_data_o;
        tx_ready_i = 1'b1;
        @(negedge clk);
        tx_ready_i = 1'b0;
    endtask

    task automatic rx_put(input logic [31:0] d);
        @(negedge clk);
        rx_valid_i = 1'b1; rx_data_i = d;
        #1;
        while (!rx_ready_o) begin @(negedge clk); #1; end
        @(negedge clk);
        rx_valid_i = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clean();
        tx_ready_i = 1'b0; rx_valid_i = 1'b0;
        bus_wr(3'd0, 32'h0);
        bus_wr(3'd1, 32'hC000_0000);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        bus_rd(3'd2, d);
        chk("R1 status", d, 32'h1010_0003);
        chk("R1 flags", {28'b0, tx_valid_o, tx_cli_empty, tx_bus_empty, rx_bus_empty},
            32'h7);
        chk("R12 full flags at reset", {30'b0, tx_bus_full, rx_bus_full}, 32'h0);
    endtask

    task automatic t_ctrl();
        logic [31:0] d;
        bus_wr(3'd0, 32'hFFFF_FFFF);
        bus_rd(3'd0, d);
        chk("R2 ctrl readback", d, 32'hE0FF_FF77);
        clean();
        bus_rd(3'd0, d);
        chk("R2 ctrl cleared", d, 32'h0);
    endtask

    task automatic t_tx_plain();
        logic [31:0] d;
        clean();
        bus_wr(3'd3, 32'h1111_0001);
        bus_wr(3'd3, 32'h2222_0002);
        idle(4);
        chk("R3 no output while disabled", {31'b0, tx_valid_o}, 32'h0);
        bus_wr(3'd0, 32'h8000_0000);
        bus_wr(3'd3, 32'h3333_0003);
        tx_take(d); chk("R3 word 0", d, 32'h1111_0001);
        tx_take(d); chk("R3 word 1", d, 32'h2222_0002);
        tx_take(d); chk("R3 word 2", d, 32'h3333_0003);
        idle(3);
        chk("R12 tx_cli_empty after drain", {31'b0, tx_cli_empty}, 32'h1);
    endtask

    task automatic t_tx_pack();
        logic [31:0] d;
        clean();
        bus_wr(3'd0, 32'h8000_0070);
        bus_wr(3'd3, 32'hBBBB_AAAA);
        tx_take(d); chk("R4 half lane 0", d, 32'h0000_AAAA);
        tx_take(d); chk("R4 half lane 1", d, 32'h0000_BBBB);
        clean();
        bus_wr(3'd0, 32'h8000_0060);
        bus_wr(3'd3, 32'h4433_2211);
        for (int i = 0; i < 4; i++) begin
            tx_take(d);
            chk("R4 byte lane", d, 32'h11 * (i + 1));
        end
    endtask

    task automatic t_rx_pack();
        logic [31:0] d;
        clean();
        bus_wr(3'd0, 32'h4000_0000);
        rx_put(32'h1234_5678);
        bus_rd(3'd4, d); chk("R5 plain word", d, 32'h1234_5678);
        bus_wr(3'd0, 32'h4000_0007);
        rx_put(32'hFFFF_1111);
        rx_put(32'hFFFF_2222);
        bus_rd(3'd4, d); chk("R5 half gather", d, 32'h2222_1111);
        bus_wr(3'd0, 32'h4000_0006);
        rx_put(32'hA1); rx_put(32'hB2); rx_put(32'hC3);
        chk("R5 incomplete word hidden", {31'b0, rx_bus_empty}, 32'h1);
        rx_put(32'hD4);
        bus_rd(3'd4, d); chk("R5 byte gather", d, 32'hD4C3_B2A1);
        rx_put(32'h01); rx_put(32'h02); rx_put(32'h03); rx_put(32'h04);
        bus_rd(3'd4, d); chk("R5 accumulator restarts", d, 32'h0403_0201);
    endtask

    task automatic t_status();
        logic [31:0] d;
        clean();
        bus_wr(3'd0, 32'h000C_0200);
        for (int i = 0; i < 4; i++) bus_wr(3'd3, 32'(i));
        bus_rd(3'd2, d); chk("R7 tx trig at threshold", d, 32'h0C10_0002);
        bus_wr(3'd3, 32'h5);
        bus_rd(3'd2, d); chk("R6 R7 tx below threshold", d, 32'h0B10_0000);
        bus_wr(3'd0, 32'h400C_0200);
        rx_put(32'h1);
        bus_rd(3'd2, d); chk("R7 rx below threshold", d, 32'h0B0F_0000);
        rx_put(32'h2);
        bus_rd(3'd2, d); chk("R6 R7 rx at threshold", d, 32'h0B0E_0001);
        bus_wr(3'd1, 32'h8000_0000);
        bus_rd(3'd2, d); chk("R10 tx clear only", d, 32'h100E_0003);
        bus_wr(3'd1, 32'h4000_0000);
        bus_rd(3'd2, d); chk("R10 rx clear", d, 32'h1010_0002);
    endtask

    task automatic t_overflow();
        logic [31:0] d;
        clean();
        for (int i = 1; i <= 17; i++) bus_wr(3'd3, 32'(i));
        chk("R12 tx_bus_full", {31'b0, tx_bus_full}, 32'h1);
        bus_rd(3'd2, d); chk("R6 tx free zero", {24'b0, d[31:24]}, 32'h0);
        bus_wr(3'd0, 32'h8000_0000);
        for (int i = 1; i <= 16; i++) begin
            tx_take(d);
            chk("R8 order kept", d, 32'(i));
        end
        idle(4);
        chk("R8 extra word dropped", {30'b0, tx_valid_o, tx_bus_empty}, 32'h1);
    endtask

    task automatic t_underflow();
        logic [31:0] d;
        clean();
        bus_rd(3'd4, d); chk("R9 empty read zero", d, 32'h0);
        bus_rd(3'd2, d); chk("R9 error flag set", {31'b0, d[2]}, 32'h1);
        bus_wr(3'd0, 32'h4000_0000);
        rx_put(32'h77);
        bus_rd(3'd4, d);
        bus_rd(3'd2, d); chk("R9 error flag sticky", {31'b0, d[2]}, 32'h1);
        bus_wr(3'd1, 32'h4000_0000);
        bus_rd(3'd2, d); chk("R9 R10 rx clear drops flag", {31'b0, d[2]}, 32'h0);
    endtask

    task automatic t_rx_full();
        logic [31:0] d;
        clean();
        bus_wr(3'd0, 32'h4000_0000);
        for (int i = 0; i < 16; i++) rx_put(32'h100 + 32'(i));
        #1;
        chk("R12 rx full flags", {29'b0, rx_bus_full, rx_cli_full, rx_ready_o}, 32'h6);
        bus_rd(3'd4, d); chk("R12 rx oldest word", d, 32'h100);
    endtask

    task automatic t_loop();
        logic [31:0] d;
        clean();
        rx_valid_i = 1'b1; rx_data_i = 32'hDEAD_BEEF; tx_ready_i = 1'b1;
        bus_wr(3'd0, 32'hE000_0000);
        bus_wr(3'd3, 32'hCAFE_0001);
        idle(6);
        chk("R11 external pins quiet", {30'b0, tx_valid_o, rx_ready_o}, 32'h0);
        bus_rd(3'd4, d); chk("R11 looped word", d, 32'hCAFE_0001);
        chk("R11 nothing from external rx", {31'b0, rx_bus_empty}, 32'h1);
        rx_valid_i = 1'b0; tx_ready_i = 1'b0;
    endtask

    task automatic t_hold();
        logic [31:0] d, first;
        clean();
        bus_wr(3'd0, 32'h8000_0000);
        bus_wr(3'd3, 32'h5A5A_0F0F);
        idle(3);
        first = tx_data_o;
        chk("R13 offered", {31'b0, tx_valid_o}, 32'h1);
        idle(3);
        chk("R13 still offered", {31'b0, tx_valid_o}, 32'h1);
        chk("R13 data stable", tx_data_o, first);
        tx_take(d); chk("R13 accepted word", d, 32'h5A5A_0F0F);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl();
        t_tx_plain();
        t_tx_pack();
        t_rx_pack();
        t_status();
        t_overflow();
        t_underflow();
        t_rx_full();
        t_loop();
        t_hold();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errs++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule